// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block connects a clocked host to a 16-bit asynchronous static RAM that has separate lower and upper byte lanes. The host presents one word request at a time through a valid/ready handshake. Each request carries an address, write data, a two-bit lane mask and a direction flag. The bridge then drives the memory's chip enable, output enable, write strobe, byte enables and address. It drives the data bus through separate output-value, output-enable and input ports, so the pad itself stays outside the block. Read data returns to the host with a one-cycle valid pulse.

Every memory timing interval is a picosecond parameter. At elaboration it becomes a whole number of clock cycles by rounding up, with a floor of one cycle. With the default 4 ns clock the counts are as follows:

| Phase | Cycles |
|---|---|
| Read strobe window | 18 |
| Bus turnaround after a read | 7 |
| Write strobe low | 15 |
| Write hold, strobe high with chip and lane enables still low | 3 |

A write ends when the write strobe rises. That single edge is the reference for address and data hold.

Top module: `asram_bridge`

## Requirements
- R1: During and after reset the bridge shows `req_ready`=1. In that state chip enable, output enable and write strobe are high, both byte enables are high (`mem_be_n`=2'b11), `mem_dq_oe`=0 and `rd_valid`=0.
- R2: A read with a nonzero mask drives the following for exactly 18 cycles from the cycle after acceptance: `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1, `mem_be_n`=~mask and `mem_dq_oe`=0.
- R3: Read data is captured at the clock edge that ends the last read-strobe cycle. `rd_valid` is high for one cycle right after that edge, and `rd_data` holds the captured word. The byte of any lane not selected by the mask reads as zero.
- R4: After a read, all strobes stay inactive for 7 cycles before `req_ready` returns. The data bus is never driven while output enable is low.
- R5: A write with a nonzero mask drives the following for exactly 15 cycles from the cycle after acceptance: `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1, `mem_be_n`=~mask, `mem_dq_oe`=1 and `mem_dq_o`=write data.
- R6: A write ends with `mem_we_n` rising while `mem_ce_n` and the selected byte enables stay low for 3 more cycles. `mem_dq_oe`=0 during those 3 cycles.
- R7: `req_ready` is low for every cycle of an access. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high.
- R8: A request with mask 2'b00 asserts no strobe and keeps `req_ready` high. For a read it gives `rd_valid`=1 with `rd_data`=0 in the next cycle. For a write it leaves memory unchanged.
- R9: Mask bit 0 selects the lower lane, data bits [7:0] on `mem_be_n[0]`. Mask bit 1 selects the upper lane, data bits [15:8] on `mem_be_n[1]`. A partial write leaves the other byte of that word unchanged in memory.
- R10: `mem_addr` holds the accepted address, unchanged, for every cycle in which `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 lower lane |
| mem_dq_o | output | 16 | Data bus value when driving |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus value seen from the memory |

## Verification
The hardest situation to reach is a write that follows a read as closely as the handshake allows. This is where the turnaround spacing between output disable and the bus drive matters. The bench keeps `req_valid` high across consecutive requests, so each new request is taken on the first cycle `req_ready` returns. This produces read-after-write, write-after-read and zero-mask requests packed back to back. The bench memory drives filler bytes on unselected lanes, so any leak of an unselected lane into `rd_data` shows up.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_WHOLD
  } asram_st_e;

  // round a time up to whole clock cycles, never below one
  function automatic int unsigned to_cycles(int unsigned t_ps, int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned N_RD  = 18,
  parameter int unsigned N_HZ  = 7,
  parameter int unsigned N_WL  = 15,
  parameter int unsigned N_WH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             mask_nz,
  input  logic             tm_zero,
  output logic             tm_load,
  output logic [CNT_W-1:0] tm_val,
  output asram_st_e        state,
  output logic             ready,
  output logic             accept
);

  asram_st_e st_q, st_d;

  assign ready  = (st_q == ST_IDLE);
  assign accept = req_valid && ready;
  assign state  = st_q;

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept && mask_nz) begin
        tm_load = 1'b1;
        if (req_write) begin
          st_d   = ST_WR;
          tm_val = CNT_W'(N_WL - 1);
        end else begin
          st_d   = ST_RD;
          tm_val = CNT_W'(N_RD - 1);
        end
      end
      ST_RD: if (tm_zero) begin
        st_d    = ST_TURN;
        tm_load = 1'b1;
        tm_val  = CNT_W'(N_HZ - 1);
      end
      ST_WR: if (tm_zero) begin
        st_d    = ST_WHOLD;
        tm_load = 1'b1;
        tm_val  = CNT_W'(N_WH - 1);
      end
      ST_TURN, ST_WHOLD: if (tm_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned T_RC_PS  = 70000,
  parameter int unsigned T_AA_PS  = 70000,
  parameter int unsigned T_DOE_PS = 35000,
  parameter int unsigned T_HZ_PS  = 25000,
  parameter int unsigned T_WC_PS  = 70000,
  parameter int unsigned T_PWE_PS = 50000,
  parameter int unsigned T_AW_PS  = 60000,
  parameter int unsigned T_SD_PS  = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_be_n,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i
);

  localparam int unsigned N_RD = max2(max2(to_cycles(T_RC_PS, CLK_PS), to_cycles(T_AA_PS, CLK_PS)),
                                      to_cycles(T_DOE_PS, CLK_PS));
  localparam int unsigned N_HZ = to_cycles(T_HZ_PS, CLK_PS);
  localparam int unsigned N_WL = max2(max2(to_cycles(T_PWE_PS, CLK_PS), to_cycles(T_AW_PS, CLK_PS)),
                                      to_cycles(T_SD_PS, CLK_PS));
  localparam int unsigned N_WC = to_cycles(T_WC_PS, CLK_PS);
  localparam int unsigned N_WH = (N_WC > N_WL + 1) ? (N_WC - N_WL) : 1;
  localparam int unsigned N_MAX = max2(max2(N_RD, N_HZ), max2(N_WL, N_WH));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);
  localparam int unsigned HZ_W  = $clog2(N_HZ + 1);

  asram_st_e        state;
  logic             accept, tm_load, tm_zero;
  logic [CNT_W-1:0] tm_val;
  logic             mask_nz;

  assign mask_nz = (req_mask != 2'b00);

  asram_seq #(
    .CNT_W(CNT_W), .N_RD(N_RD), .N_HZ(N_HZ), .N_WL(N_WL), .N_WH(N_WH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .mask_nz(mask_nz), .tm_zero(tm_zero), .tm_load(tm_load), .tm_val(tm_val),
    .state(state), .ready(req_ready), .accept(accept)
  );

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .zero(tm_zero)
  );

  // request capture
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic [1:0]        mask_q;
  logic              req_en;

  assign req_en = accept && mask_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (req_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  // strobe decode
  always_comb begin
    mem_ce_n  = 1'b1;
    mem_oe_n  = 1'b1;
    mem_we_n  = 1'b1;
    mem_be_n  = 2'b11;
    mem_dq_oe = 1'b0;
    unique case (state)
      ST_RD: begin
        mem_ce_n = 1'b0;
        mem_oe_n = 1'b0;
        mem_be_n = ~mask_q;
      end
      ST_WR: begin
        mem_ce_n  = 1'b0;
        mem_we_n  = 1'b0;
        mem_be_n  = ~mask_q;
        mem_dq_oe = 1'b1;
      end
      ST_WHOLD: begin
        mem_ce_n = 1'b0;
        mem_be_n = ~mask_q;
      end
      default: ;
    endcase
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;

  // read return
  logic        cap, zrd, rdv_d;
  logic [15:0] lane_mask, rdd_d;

  assign lane_mask = {{8{mask_q[1]}}, {8{mask_q[0]}}};
  assign cap       = (state == ST_RD) && tm_zero;
  assign zrd       = accept && !mask_nz && !req_write;

  always_comb begin
    rdv_d = cap || zrd;
    rdd_d = cap ? (mem_dq_i & lane_mask) : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rdv_d;
      if (rdv_d) rd_data <= rdd_d;
    end
  end

  // ---------------- assertions ----------------
  logic [HZ_W-1:0] hz_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hz_cnt <= HZ_W'(N_HZ);
    else if (!mem_oe_n)               hz_cnt <= '0;
    else if (hz_cnt < HZ_W'(N_HZ))    hz_cnt <= hz_cnt + 1'b1;
  end

  // R4
  bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (hz_cnt >= HZ_W'(N_HZ)));

  // R5
  we_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_be_n != 2'b11 && mem_oe_n));

  // R6
  we_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_be_n != 2'b11 && !mem_dq_oe));

  // R7
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_bridge_bench.sv
module asram_bridge_bench;

  localparam int AW   = 18;
  localparam int NRD  = 18;
  localparam int NHZ  = 7;
  localparam int NWL  = 15;
  localparam int NWH  = 3;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_mask;
  logic          rd_valid;
  logic [15:0]   rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [15:0]   mem_dq_o, mem_dq_i;

  asram_bridge u_asram_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // memory array seen by the bridge, and the bench's own expectation of it
  logic [15:0] mem   [256];
  logic [15:0] shadow[256];

  always_comb begin
    mem_dq_i = 16'hA5A5;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_be_n[0]) mem_dq_i[7:0]  = mem[mem_addr[7:0]][7:0];
      if (!mem_be_n[1]) mem_dq_i[15:8] = mem[mem_addr[7:0]][15:8];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  // behavioural reference: kind 0 idle, 1 read, 2 write; t = cycles since accept
  int          m_kind, m_t;
  bit          m_zv;
  logic [AW-1:0] m_addr;
  logic [15:0] m_wdata, m_rexp;
  logic [1:0]  m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind <= 0; m_t <= 0; m_zv <= 0;
    end else begin
      m_zv <= 0;
      if (m_kind == 0) begin
        if (req_valid) begin
          if (req_mask == 2'b00) begin
            if (!req_write) m_zv <= 1;
          end else begin
            m_kind  <= req_write ? 2 : 1;
            m_t     <= 0;
            m_addr  <= req_addr;
            m_wdata <= req_wdata;
            m_mask  <= req_mask;
            m_rexp  <= shadow[req_addr[7:0]] & {{8{req_mask[1]}}, {8{req_mask[0]}}};
            if (req_write) begin
              if (req_mask[0]) shadow[req_addr[7:0]][7:0]  <= req_wdata[7:0];
              if (req_mask[1]) shadow[req_addr[7:0]][15:8] <= req_wdata[15:8];
            end
          end
        end
      end else if ((m_kind == 1 && m_t == NRD + NHZ - 1) || (m_kind == 2 && m_t == NWL + NWH - 1)) begin
        m_kind <= 0;
      end else begin
        m_t <= m_t + 1;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic ece, eoe, ewe, edq, erv;
      logic [1:0] ebe;
      ece = 1; eoe = 1; ewe = 1; edq = 0; ebe = 2'b11;
      if (m_kind == 1 && m_t < NRD) begin
        ece = 0; eoe = 0; ebe = ~m_mask;
      end else if (m_kind == 2 && m_t < NWL) begin
        ece = 0; ewe = 0; edq = 1; ebe = ~m_mask;
      end else if (m_kind == 2) begin
        ece = 0; ebe = ~m_mask;
      end
      erv = m_zv || (m_kind == 1 && m_t == NRD);
      // R7 ready tracks the access
      chk(req_ready == (m_kind == 0), "R7 req_ready", req_ready, m_kind == 0);
      // R2 R4 R5 R6 strobes by phase
      chk(mem_ce_n == ece, "R2/R5/R6 mem_ce_n", mem_ce_n, ece);
      chk(mem_oe_n == eoe, "R2/R4 mem_oe_n", mem_oe_n, eoe);
      chk(mem_we_n == ewe, "R5/R6 mem_we_n", mem_we_n, ewe);
      chk(mem_dq_oe == edq, "R4/R5/R6 mem_dq_oe", mem_dq_oe, edq);
      // R9 lane enables
      chk(mem_be_n == ebe, "R9 mem_be_n", mem_be_n, ebe);
      if (edq) chk(mem_dq_o == m_wdata, "R5 mem_dq_o", mem_dq_o, m_wdata);
      // R10 address held
      if (!ece) chk(mem_addr == m_addr, "R10 mem_addr", mem_addr, m_addr);
      // R3 R8 read return
      chk(rd_valid == erv, "R3/R8 rd_valid", rd_valid, erv);
      if (erv && m_zv) chk(rd_data == 16'h0, "R8 rd_data", rd_data, 16'h0);
      else if (erv)    chk(rd_data == m_rexp, "R3 rd_data", rd_data, m_rexp);
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0101 + 16'h3C00);
      shadow[i] = 16'(i * 16'h0101 + 16'h3C00);
    end
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = 2'b00;
    repeat (3) @(negedge clk);
    // R1 idle state while reset is held
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(mem_be_n == 2'b11 && !mem_dq_oe && !rd_valid, "R1 lanes/bus in reset", {mem_be_n, mem_dq_oe, rd_valid}, 4'b1100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    issue(1, 18'd5, 16'h1234, 2'b11);   // full write
    issue(0, 18'd5, 16'h0,    2'b11);   // read right after write
    issue(1, 18'd6, 16'hBEEF, 2'b11);   // write right after read (turnaround, R4)
    issue(1, 18'd5, 16'hFF56, 2'b01);   // lower lane only (R9)
    issue(1, 18'd5, 16'h99FF, 2'b10);   // upper lane only (R9)
    issue(0, 18'd5, 16'h0,    2'b11);   // expect 9956
    issue(0, 18'd6, 16'h0,    2'b01);   // partial read, upper zero (R3)
    issue(0, 18'd6, 16'h0,    2'b10);   // partial read, lower zero (R3)
    issue(1, 18'd6, 16'h0000, 2'b00);   // zero-mask write (R8)
    issue(0, 18'd7, 16'h0,    2'b00);   // zero-mask read (R8)
    issue(0, 18'd7, 16'h0,    2'b00);   // back-to-back zero-mask read
    issue(0, 18'd6, 16'h0,    2'b11);   // still BEEF (R8)
    issue(0, 18'd9, 16'h0,    2'b11);   // untouched word
    req_valid = 0;
    repeat (40) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d (actual=running expected=finished)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule